// File: doc/BRIEF.md
# Read-Only Floppy Drive Emulator

This block stands behind a small window of peripheral I/O addresses and behaves, for the CPU, like a read-only floppy drive. Software turns four stepper-motor phase coils on and off by touching addresses in the window. The block follows the coil pulses and keeps the head position in half-track steps. The track number is half of that position.

When the track number changes, the block fills an on-chip track memory with the new track image. It asks an external storage reader for fixed-size blocks one at a time and writes each returned byte into place. The image is 26 blocks of 256 bytes, stored already encoded. A free-running rotation counter moves through the track memory at a steady rate to stand in for a spinning disk. Each read of the data-latch address returns the byte under the emulated head. Reads are still served while a load is running.

Top module: `disk_track_emu`

## Requirements
- R1: While reset is held and on the first cycle after it: `head_pos` is 0, `phase_on` is 0, and the block is loading track 0 (`busy` and `blk_req` high, `blk_idx` 0).
- R2: An access with `io_addr[3]`=0 sets phase coil `io_addr[2:1]` to the value of `io_addr[0]`. This is visible on `phase_on` after the access edge. An access with `io_addr[3]`=1 changes neither `phase_on` nor `head_pos`.
- R3: Turning on a coil that was off moves `head_pos` up by one when the coil number equals (`head_pos`+1) mod 4, and down by one when it equals (`head_pos`-1) mod 4. Turning a coil off, or turning on the coil opposite the position, leaves `head_pos` unchanged. `track_num` is `head_pos`/2.
- R4: `head_pos` never goes below 0 or above 69. A step request past either end is ignored.
- R5: A change of `track_num` starts a new load one cycle later, even if a load is already running. The new load starts at block 0 of the new track, with `busy` high. A half-step that stays within one track starts no load.
- R6: A load requests block indices track*26+n for n=0..25, in order. Each accepted byte (`blk_valid` high while `blk_req` is high) fills the next byte of the current block. Byte k of block n lands at track address n*256+k. After 256 bytes the next block is requested. `busy` and `blk_req` fall after byte 255 of block 25. Gaps in `blk_valid` only stall the load.
- R7: An access at `io_addr`=4'hC returns, on `rd_data` one clock later, the track-memory byte at the rotation address of the access cycle.
- R8: The rotation address starts at 0. It advances by one after every TICK_DIV cycles with `cpu_tick` high, and wraps from 6655 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One pulse per emulated CPU cycle |
| io_strobe | input | 1 | One-cycle access to the drive I/O window |
| io_addr | input | 4 | Low address nibble of the access |
| rd_data | output | 8 | Byte returned for a data-latch read |
| phase_on | output | 4 | Present state of the four phase coils |
| head_pos | output | 7 | Head position in half-tracks |
| track_num | output | 6 | Current track number |
| busy | output | 1 | Track load in progress |
| blk_req | output | 1 | Block read request to storage |
| blk_idx | output | 16 | Index of the requested storage block |
| blk_valid | input | 1 | Storage byte valid this cycle |
| blk_data | input | 8 | Storage byte |

## Verification
The stepping logic is tried with four kinds of coil pulses: adjacent-up, adjacent-down, opposite-coil, and pushes past both end stops. This separates a correct direction rule from one that reacts to any coil, and shows whether the clamp works. Track loads run with storage bytes on every cycle and with bytes on alternate cycles, which separates counting accepted bytes from counting cycles. One load is cut off mid-block by a track change, which checks that a restart resets the block and byte counters. The bench computes storage contents from the block index and byte number, so reads at many rotation positions, including both sides of the wrap, confirm the placement of every block and the rotation rate.

// File: rtl/disk_emu_pkg.sv
package disk_emu_pkg;
   // address nibble of the data latch read
   localparam logic [3:0] DATA_LATCH_ADDR = 4'hC;

   typedef logic [7:0] byte_t;

   // coil number one half-step above / below a given coil
   function automatic logic [1:0] coil_above(input logic [1:0] c);
      return c + 2'd1;
   endfunction

   function automatic logic [1:0] coil_below(input logic [1:0] c);
      return c - 2'd1;
   endfunction
endpackage

// File: rtl/disk_head_stepper.sv
module disk_head_stepper
   import disk_emu_pkg::*;
#(
   parameter int MAX_HALF = 69,
   parameter int POS_W    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic [3:0]       addr,
   output logic [3:0]       phases,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] POS_MAX = POS_W'(MAX_HALF);

   logic [1:0] sel;
   logic       coil_wr, energize, go_up, go_dn;

   assign sel      = addr[2:1];
   assign coil_wr  = acc & ~addr[3];
   assign energize = coil_wr & addr[0] & ~phases[sel];
   assign go_up    = energize && (sel == coil_above(pos[1:0]));
   assign go_dn    = energize && (sel == coil_below(pos[1:0]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phases <= '0;
         pos    <= '0;
      end else begin
         if (coil_wr)
            phases[sel] <= addr[0];
         if (go_up && pos != POS_MAX)
            pos <= pos + POS_W'(1);
         else if (go_dn && pos != '0)
            pos <= pos - POS_W'(1);
      end
   end

   // R4
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= POS_MAX);
   // R3
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pos == $past(pos) || pos == $past(pos) + POS_W'(1)
                || pos == $past(pos) - POS_W'(1)));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && !addr[3]) |=> ($stable(pos) && $stable(phases)));
endmodule

// File: rtl/disk_track_loader.sv
module disk_track_loader
   import disk_emu_pkg::*;
#(
   parameter int BLOCK_BYTES = 256,
   parameter int BLOCKS      = 26,
   parameter int TRK_W       = 6,
   parameter int IDX_W       = 16,
   parameter int ADDR_W      = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRK_W-1:0]  track_now,
   input  logic              blk_valid,
   input  byte_t             blk_data,
   output logic              loading,
   output logic [IDX_W-1:0]  blk_idx,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output byte_t             wr_data
);
   localparam int BOFF_W = $clog2(BLOCK_BYTES);
   localparam int BN_W   = $clog2(BLOCKS);
   localparam logic [BOFF_W-1:0] LAST_OFF = BOFF_W'(BLOCK_BYTES - 1);
   localparam logic [BN_W-1:0]   LAST_BLK = BN_W'(BLOCKS - 1);

   logic [BN_W-1:0]   blk_n;
   logic [BOFF_W-1:0] boff;
   logic [TRK_W-1:0]  load_trk;
   logic              moved;

   assign moved   = (track_now != load_trk);
   assign wr_en   = loading & blk_valid & ~moved;
   assign wr_addr = ADDR_W'(blk_n) * ADDR_W'(BLOCK_BYTES) + ADDR_W'(boff);
   assign wr_data = blk_data;
   assign blk_idx = IDX_W'(load_trk) * IDX_W'(BLOCKS) + IDX_W'(blk_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loading  <= 1'b1;
         blk_n    <= '0;
         boff     <= '0;
         load_trk <= '0;
      end else if (moved) begin
         load_trk <= track_now;
         loading  <= 1'b1;
         blk_n    <= '0;
         boff     <= '0;
      end else if (wr_en) begin
         if (boff == LAST_OFF) begin
            boff <= '0;
            if (blk_n == LAST_BLK) begin
               blk_n   <= '0;
               loading <= 1'b0;
            end else begin
               blk_n <= blk_n + BN_W'(1);
            end
         end else begin
            boff <= boff + BOFF_W'(1);
         end
      end
   end

   // R5
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      moved |=> (loading && blk_n == '0 && boff == '0));
   // R6
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loading) |-> $past(wr_en));
endmodule

// File: rtl/disk_rotation.sv
module disk_rotation #(
   parameter int TRACK_BYTES = 6656,
   parameter int ADDR_W      = 13,
   parameter int TICK_DIV    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   output logic [ADDR_W-1:0] rot
);
   localparam int DIV_W = $clog2(TICK_DIV);
   localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(TICK_DIV - 1);
   localparam logic [ADDR_W-1:0] ROT_LAST = ADDR_W'(TRACK_BYTES - 1);
   localparam bit POW2 = (TRACK_BYTES == (1 << ADDR_W));

   logic [DIV_W-1:0] div;
   logic             adv;

   assign adv = tick && (div == DIV_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)   div <= '0;
      else if (adv) div <= '0;
      else if (tick) div <= div + DIV_W'(1);
   end

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk) begin
            if (!rst_n)   rot <= '0;
            else if (adv) rot <= rot + ADDR_W'(1);
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)   rot <= '0;
            else if (adv) rot <= (rot == ROT_LAST) ? '0 : rot + ADDR_W'(1);
         end
      end
   endgenerate

   // R8
   rot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rot <= ROT_LAST);
   // R8
   rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(rot));
endmodule

// File: rtl/disk_track_ram.sv
module disk_track_ram
   import disk_emu_pkg::*;
#(
   parameter int DEPTH  = 6656,
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  byte_t             wd,
   input  logic              re,
   input  logic [ADDR_W-1:0] ra,
   output byte_t             q
);
   byte_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= mem[ra];
   end
endmodule

// File: rtl/disk_track_emu.sv
module disk_track_emu
   import disk_emu_pkg::*;
#(
   parameter int BLOCK_BYTES      = 256,
   parameter int BLOCKS_PER_TRACK = 26,
   parameter int NUM_TRACKS       = 35,
   parameter int TICK_DIV         = 32,
   parameter int IDX_W            = 16,
   localparam int TRK_W           = $clog2(NUM_TRACKS),
   localparam int POS_W           = TRK_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_tick,
   input  logic             io_strobe,
   input  logic [3:0]       io_addr,
   output logic [7:0]       rd_data,
   output logic [3:0]       phase_on,
   output logic [POS_W-1:0] head_pos,
   output logic [TRK_W-1:0] track_num,
   output logic             busy,
   output logic             blk_req,
   output logic [IDX_W-1:0] blk_idx,
   input  logic             blk_valid,
   input  logic [7:0]       blk_data
);
   localparam int TRACK_BYTES = BLOCK_BYTES * BLOCKS_PER_TRACK;
   localparam int ADDR_W      = $clog2(TRACK_BYTES);
   localparam int MAX_HALF    = 2 * NUM_TRACKS - 1;

   generate
      if (NUM_TRACKS < 2) begin : g_bad_trk
         $error("NUM_TRACKS must be at least 2");
      end
      if (BLOCKS_PER_TRACK < 2 || BLOCK_BYTES < 2) begin : g_bad_blk
         $error("block size and block count must be at least 2");
      end
      if (TICK_DIV < 2) begin : g_bad_div
         $error("TICK_DIV must be at least 2");
      end
      if (NUM_TRACKS * BLOCKS_PER_TRACK > (1 << IDX_W)) begin : g_bad_idx
         $error("IDX_W too narrow for all block indices");
      end
   endgenerate

   logic              wr_en, rd_en, loading;
   logic [ADDR_W-1:0] wr_addr, rot;
   byte_t             wr_data;

   assign rd_en     = io_strobe && (io_addr == DATA_LATCH_ADDR);
   assign track_num = head_pos[POS_W-1:1];
   assign busy      = loading;
   assign blk_req   = loading;

   disk_head_stepper #(.MAX_HALF(MAX_HALF), .POS_W(POS_W)) u_head (
      .clk(clk), .rst_n(rst_n), .acc(io_strobe), .addr(io_addr),
      .phases(phase_on), .pos(head_pos));

   disk_track_loader #(.BLOCK_BYTES(BLOCK_BYTES), .BLOCKS(BLOCKS_PER_TRACK),
      .TRK_W(TRK_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_load (
      .clk(clk), .rst_n(rst_n), .track_now(track_num),
      .blk_valid(blk_valid), .blk_data(blk_data), .loading(loading),
      .blk_idx(blk_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   disk_rotation #(.TRACK_BYTES(TRACK_BYTES), .ADDR_W(ADDR_W),
      .TICK_DIV(TICK_DIV)) u_rot (
      .clk(clk), .rst_n(rst_n), .tick(cpu_tick), .rot(rot));

   disk_track_ram #(.DEPTH(TRACK_BYTES), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .wa(wr_addr), .wd(wr_data),
      .re(rd_en), .ra(rot), .q(rd_data));
endmodule

// File: tb/tb_disk_track_emu.sv
module tb_disk_track_emu;
   localparam int BB  = 256;
   localparam int BPT = 26;
   localparam int TB  = BB * BPT;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_tick = 1'b0;
   logic        io_strobe = 1'b0;
   logic [3:0]  io_addr = 4'h0;
   logic [7:0]  rd_data;
   logic [3:0]  phase_on;
   logic [6:0]  head_pos;
   logic [5:0]  track_num;
   logic        busy, blk_req;
   logic [15:0] blk_idx;
   logic        blk_valid = 1'b0;
   logic [7:0]  blk_data = 8'h00;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   disk_track_emu #(.TICK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .io_strobe(io_strobe),
      .io_addr(io_addr), .rd_data(rd_data), .phase_on(phase_on),
      .head_pos(head_pos), .track_num(track_num), .busy(busy),
      .blk_req(blk_req), .blk_idx(blk_idx), .blk_valid(blk_valid),
      .blk_data(blk_data));

   always #2.5 clk = ~clk;

   function automatic logic [7:0] fdat(input int idx, input int k);
      return 8'((idx * 5 + k * 3 + 1) & 255);
   endfunction

   // ---------------- storage source ----------------
   bit src_gap = 1'b0;
   bit gap_ph  = 1'b0;
   int last_idx = -1;
   int k_src = 0;
   int src_bytes = 0;
   int src_last = -1;

   always @(negedge clk) begin
      if (rst_n && blk_req) begin
         if (int'(blk_idx) != last_idx) begin
            k_src = 0;
            if (int'(blk_idx) % BPT == 0) src_bytes = 0;
         end
         last_idx = int'(blk_idx);
         if (!src_gap || gap_ph) begin
            blk_valid = 1'b1;
            blk_data  = fdat(int'(blk_idx), k_src);
            k_src++;
            src_bytes++;
            src_last = int'(blk_idx);
         end else begin
            blk_valid = 1'b0;
         end
         gap_ph = ~gap_ph;
      end else begin
         blk_valid = 1'b0;
      end
   end

   // ---------------- rotation and read model ----------------
   int mdl_div = 0;
   int mdl_rot = 0;
   int loaded_trk = 0;
   logic [7:0] exp_rd = 8'h00;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         mdl_div <= 0;
         mdl_rot <= 0;
      end else begin
         if (io_strobe && io_addr == 4'hC)
            exp_rd <= fdat(loaded_trk * BPT + mdl_rot / BB, mdl_rot % BB);
         if (cpu_tick) begin
            if (mdl_div == DIV - 1) begin
               mdl_div <= 0;
               mdl_rot <= (mdl_rot == TB - 1) ? 0 : mdl_rot + 1;
            end else begin
               mdl_div <= mdl_div + 1;
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic access(input logic [3:0] a);
      @(negedge clk);
      io_strobe = 1'b1;
      io_addr   = a;
      @(negedge clk);
      io_strobe = 1'b0;
   endtask

   task automatic read_chk(input string req);
      access(4'hC);
      chk(rd_data == exp_rd, req, rd_data, exp_rd);
   endtask

   task automatic wait_load(input int trk);
      int guard = 0;
      while (busy && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      chk(!busy, "R6 load ends", busy, 0);
      chk(src_last == trk * BPT + BPT - 1, "R6 last block index", src_last, trk * BPT + BPT - 1);
      chk(src_bytes == TB, "R6 bytes per load", src_bytes, TB);
      loaded_trk = trk;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(head_pos == 0, "R1 head in reset", head_pos, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cpu_tick = 1'b1;
      @(negedge clk);
      chk(head_pos == 0, "R1 head", head_pos, 0);
      chk(phase_on == 0, "R1 phases", phase_on, 0);
      chk(busy && blk_req, "R1 busy/req", {busy, blk_req}, 3);
      chk(blk_idx == 0, "R1 idx", blk_idx, 0);
   endtask

   task automatic t_first_load();
      wait_load(0);
      read_chk("R7 read a");
      repeat (37) @(negedge clk);
      read_chk("R7 read b");
      repeat (1500) @(negedge clk);
      read_chk("R7 read c");
   endtask

   task automatic t_ignored();
      foreach (ign[i]) begin end
   endtask
   logic [3:0] ign [7] = '{4'h8, 4'h9, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};

   task automatic t_io_window();
      for (int i = 0; i < 7; i++) access(ign[i]);
      read_chk("R7 read after ignored");
      chk(phase_on == 0, "R2 ignored phases", phase_on, 0);
      chk(head_pos == 0, "R2 ignored head", head_pos, 0);
      access(4'h3);
      chk(phase_on == 4'b0010, "R2 coil on", phase_on, 2);
      chk(head_pos == 1, "R3 step up", head_pos, 1);
      access(4'h2);
      chk(phase_on == 0, "R2 coil off", phase_on, 0);
      chk(head_pos == 1, "R3 off no move", head_pos, 1);
      @(negedge clk);
      chk(!busy, "R5 half step no load", busy, 0);
   endtask

   task automatic t_low_end();
      access(4'h1);
      chk(head_pos == 0, "R3 step down", head_pos, 0);
      access(4'h0);
      access(4'h7);
      chk(head_pos == 0, "R4 clamp low", head_pos, 0);
      access(4'h6);
      access(4'h5);
      chk(head_pos == 0, "R3 opposite coil", head_pos, 0);
      access(4'h4);
   endtask

   task automatic t_gap_load();
      access(4'h3);
      access(4'h2);
      access(4'h5);
      chk(track_num == 1, "R3 track number", track_num, 1);
      @(negedge clk);
      chk(busy && blk_req, "R5 load start", {busy, blk_req}, 3);
      chk(blk_idx == 26, "R5 first idx", blk_idx, 26);
      src_gap = 1'b1;
      access(4'h4);
      wait_load(1);
      src_gap = 1'b0;
      read_chk("R6 gap load read a");
      repeat (333) @(negedge clk);
      read_chk("R6 gap load read b");
   endtask

   task automatic t_restart();
      access(4'h7);
      access(4'h6);
      chk(head_pos == 3, "R3 pos 3", head_pos, 3);
      @(negedge clk);
      chk(!busy, "R5 same track", busy, 0);
      access(4'h1);
      access(4'h0);
      chk(track_num == 2, "R3 track 2", track_num, 2);
      repeat (300) @(negedge clk);
      access(4'h3);
      access(4'h2);
      access(4'h5);
      @(negedge clk);
      chk(blk_idx == 78, "R5 restart idx", blk_idx, 78);
      access(4'h4);
      wait_load(3);
      read_chk("R5 restart read a");
      repeat (911) @(negedge clk);
      read_chk("R5 restart read b");
   endtask

   task automatic t_climb();
      int p = 6;
      for (int i = 0; i < 64; i++) begin
         logic [1:0] a;
         a = 2'((p + 1) % 4);
         access({1'b0, a, 1'b1});
         access({1'b0, a, 1'b0});
         if (p < 69) p++;
      end
      chk(head_pos == 69, "R4 reach top", head_pos, 69);
      chk(track_num == 34, "R3 top track", track_num, 34);
      wait_load(34);
      chk(blk_idx == 34 * BPT, "R6 idx rests", blk_idx, 34 * BPT);
      read_chk("R7 top track read");
   endtask

   task automatic t_wrap();
      int guard = 0;
      while (mdl_rot != TB - 1 && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      read_chk("R8 before wrap");
      chk(rd_data == fdat(34 * BPT + BPT - 1, BB - 1), "R8 last byte", rd_data,
          fdat(34 * BPT + BPT - 1, BB - 1));
      guard = 0;
      while (mdl_rot != 0 && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      read_chk("R8 after wrap");
      chk(rd_data == fdat(34 * BPT, 0), "R8 wrap to 0", rd_data, fdat(34 * BPT, 0));
   endtask

   // ---------------- watchdog ----------------
   always @(negedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_first_load();
      t_io_window();
      t_low_end();
      t_gap_load();
      t_restart();
      t_climb();
      access(4'h5);
      chk(head_pos == 69, "R4 clamp high", head_pos, 69);
      access(4'h4);
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule